// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block watches the two instruction words that sit in front of the execute stage of a five-stage integer pipeline: the word latched between decode and execute, and the word latched between fetch and decode. When the older word is a load and the younger word reads the register that load will write, the younger instruction cannot obtain its operand in time, even with forwarding. The block then asserts a one-cycle stall.

The detector is purely combinational. The stall drives three things. It forces the control field headed into the execute stage to all zeros, which turns it into a bubble. It tells the fetch/decode latch to keep its contents. It tells the program counter to hold its value. The registers that a consumer reads depend on its class. A register-register ALU consumer is checked on both source fields. Loads, stores, ALU-immediate operations and branches are checked only on the first source field. All opcode values are parameters.

Top module: `load_interlock`

## Requirements
- R1: If the decode/execute word has a load opcode (default 6'h23, bits [31:26]) whose destination (bits [20:16]) is non-zero, and the fetch/decode word is register-register ALU (opcode 6'h00), then `stall` is 1 when the destination equals the consumer's first source field (bits [25:21]).
- R2: In the same register-register case, `stall` is also 1 when the destination equals the consumer's second source field (bits [20:16]). A match on the consumer's own destination field (bits [15:11]) alone causes no stall.
- R3: If the consumer is a load (6'h23), a store (6'h2B), a branch (6'h04, 6'h05) or an ALU-immediate (6'h08 to 6'h0F), `stall` is 1 only when the load destination equals the consumer's bits [25:21]. A match on bits [20:16] alone gives `stall` 0.
- R4: A load whose destination is register 0 never raises `stall`.
- R5: When the decode/execute word is not a load, `stall` is 0 whatever the fetch/decode word holds.
- R6: A consumer whose opcode belongs to none of the classes above (for example 6'h02 or 6'h10) never raises `stall`.
- R7: While `stall` is 1, `idex_ctrl_out` is all zeros. Otherwise it equals `idex_ctrl_in`.
- R8: `ifid_hold` and `pc_hold` always equal `stall`.
- R9: The stall lasts one cycle per load-use pair. Once the bubble (an all-zero word) reaches the decode/execute position while the consumer is held, `stall` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_instr | input | 32 | Instruction word in the decode/execute latch |
| ifid_instr | input | 32 | Instruction word in the fetch/decode latch |
| idex_ctrl_in | input | CTRL_W | Decoded control field headed into execute |
| idex_ctrl_out | output | CTRL_W | Control field after bubble insertion |
| stall | output | 1 | Load-use hazard detected |
| ifid_hold | output | 1 | Keep the fetch/decode latch contents |
| pc_hold | output | 1 | Keep the program counter value |

## Verification
The hardest case to reach is the release after a stall. It only appears when the surrounding pipeline has already reacted to the stall: the bubble moves into the decode/execute position while the consumer stays in fetch/decode. The bench models that step. It drives a stalling pair, then replaces the older word with the all-zero bubble and keeps the younger word as it was. Further near-miss vectors check the field selection, where a register matches only in a field that the consumer's class does not read.

// File: rtl/load_interlock.sv
module load_interlock #(
  parameter int          CTRL_W    = 16,
  parameter logic [5:0]  OP_LOAD   = 6'h23,
  parameter logic [5:0]  OP_STORE  = 6'h2B,
  parameter logic [5:0]  OP_RR     = 6'h00,
  parameter logic [5:0]  OP_BR_A   = 6'h04,
  parameter logic [5:0]  OP_BR_B   = 6'h05,
  parameter logic [5:0]  OP_IMM_LO = 6'h08,
  parameter logic [5:0]  OP_IMM_HI = 6'h0F
) (
  input  logic [31:0]       idex_instr,
  input  logic [31:0]       ifid_instr,
  input  logic [CTRL_W-1:0] idex_ctrl_in,
  output logic [CTRL_W-1:0] idex_ctrl_out,
  output logic              stall,
  output logic              ifid_hold,
  output logic              pc_hold
);
  logic [5:0] ex_op, id_op;
  logic [4:0] ex_dst, id_src_a, id_src_b;
  logic       ex_load, id_rr, id_one_src, hit_a, hit_b;

  assign ex_op    = idex_instr[31:26];
  assign ex_dst   = idex_instr[20:16];
  assign id_op    = ifid_instr[31:26];
  assign id_src_a = ifid_instr[25:21];
  assign id_src_b = ifid_instr[20:16];

  assign ex_load    = (ex_op == OP_LOAD) && (ex_dst != 5'd0);
  assign id_rr      = (id_op == OP_RR);
  assign id_one_src = (id_op == OP_LOAD) || (id_op == OP_STORE) ||
                      (id_op == OP_BR_A) || (id_op == OP_BR_B) ||
                      ((id_op >= OP_IMM_LO) && (id_op <= OP_IMM_HI));
  assign hit_a = (ex_dst == id_src_a);
  assign hit_b = (ex_dst == id_src_b);

  assign stall         = ex_load && ((id_rr && (hit_a || hit_b)) || (id_one_src && hit_a));
  assign ifid_hold     = stall;
  assign pc_hold       = stall;
  assign idex_ctrl_out = stall ? '0 : idex_ctrl_in;
endmodule

module load_interlock_chk #(
  parameter int         CTRL_W  = 16,
  parameter logic [5:0] OP_LOAD = 6'h23
) (
  input logic [31:0]       idex_instr,
  input logic [31:0]       ifid_instr,
  input logic [CTRL_W-1:0] idex_ctrl_in,
  input logic [CTRL_W-1:0] idex_ctrl_out,
  input logic              stall,
  input logic              ifid_hold,
  input logic              pc_hold
);
  always_comb begin
    p_needs_load_r5: assert (!stall || idex_instr[31:26] == OP_LOAD);
    p_no_zero_dst_r4: assert (!stall || idex_instr[20:16] != 5'd0);
    p_field_match_r1: assert (!stall || idex_instr[20:16] == ifid_instr[25:21]
                              || idex_instr[20:16] == ifid_instr[20:16]);
    p_bubble_r7: assert (!stall || idex_ctrl_out == '0);
    p_pass_r7: assert (stall || idex_ctrl_out == idex_ctrl_in);
    p_holds_r8: assert (ifid_hold == stall && pc_hold == stall);
    p_bubble_release_r9: assert (idex_instr != 32'd0 || !stall);
  end
endmodule

bind load_interlock load_interlock_chk #(.CTRL_W(CTRL_W), .OP_LOAD(OP_LOAD)) chk_i (
  .idex_instr(idex_instr), .ifid_instr(ifid_instr), .idex_ctrl_in(idex_ctrl_in),
  .idex_ctrl_out(idex_ctrl_out), .stall(stall), .ifid_hold(ifid_hold), .pc_hold(pc_hold)
);

// File: tb/load_interlock_tb.sv
module load_interlock_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0]   idex_instr, ifid_instr;
  logic [CW-1:0] ctrl_in, ctrl_out;
  logic          stall, ifid_hold, pc_hold;

  load_interlock #(.CTRL_W(CW)) dut_i (
    .idex_instr(idex_instr), .ifid_instr(ifid_instr), .idex_ctrl_in(ctrl_in),
    .idex_ctrl_out(ctrl_out), .stall(stall), .ifid_hold(ifid_hold), .pc_hold(pc_hold)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] a,
                                      input logic [4:0] b, input logic [4:0] d);
    return {op, a, b, d, 11'd0};
  endfunction

  typedef struct packed {
    logic [31:0] ex;
    logic [31:0] id;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{enc(6'h23,1,5,0), enc(6'h00,5,2,3), 1'b1, 4'd1},   // R1 rr first source
    '{enc(6'h23,1,5,0), enc(6'h00,2,5,3), 1'b1, 4'd2},   // R2 rr second source
    '{enc(6'h23,1,5,0), enc(6'h00,2,3,5), 1'b0, 4'd2},   // R2 rr own dest only
    '{enc(6'h23,1,31,0), enc(6'h00,4,31,6), 1'b1, 4'd2}, // R2 register 31
    '{enc(6'h23,1,5,0), enc(6'h23,5,6,0), 1'b1, 4'd3},   // R3 load base
    '{enc(6'h23,1,5,0), enc(6'h2B,5,6,0), 1'b1, 4'd3},   // R3 store base
    '{enc(6'h23,1,5,0), enc(6'h2B,1,5,0), 1'b0, 4'd3},   // R3 store data only
    '{enc(6'h23,1,5,0), enc(6'h0C,5,9,0), 1'b1, 4'd3},   // R3 imm source
    '{enc(6'h23,1,5,0), enc(6'h0F,2,5,0), 1'b0, 4'd3},   // R3 imm target only
    '{enc(6'h23,1,5,0), enc(6'h04,5,2,0), 1'b1, 4'd3},   // R3 branch first
    '{enc(6'h23,1,5,0), enc(6'h05,2,5,0), 1'b0, 4'd3},   // R3 branch second only
    '{enc(6'h23,1,0,0), enc(6'h00,0,0,4), 1'b0, 4'd4},   // R4 dest r0
    '{enc(6'h00,2,3,5), enc(6'h00,5,5,1), 1'b0, 4'd5},   // R5 rr older
    '{enc(6'h2B,1,5,0), enc(6'h23,5,5,0), 1'b0, 4'd5},   // R5 store older
    '{enc(6'h23,1,7,0), enc(6'h02,7,7,0), 1'b0, 4'd6},   // R6 jump class
    '{enc(6'h23,1,7,0), enc(6'h10,7,7,0), 1'b0, 4'd6},   // R6 past imm range
    '{enc(6'h23,1,7,0), enc(6'h07,7,7,0), 1'b0, 4'd6}    // R6 below imm range
  };

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ex, input logic [31:0] id, input logic [CW-1:0] c,
                       input logic exp, input string tag);
    @(posedge clk);
    idex_instr = ex; ifid_instr = id; ctrl_in = c;
    @(negedge clk);
    check(tag, {29'd0, stall, ifid_hold, pc_hold}, {29'd0, exp, exp, exp});
    check("R7 ctrl", {16'd0, ctrl_out}, {16'd0, exp ? 16'd0 : c});
  endtask

  initial begin
    idex_instr = '0; ifid_instr = '0; ctrl_in = '0;
    @(negedge clk);
    check("R5 idle", {29'd0, stall, ifid_hold, pc_hold}, 32'd0);
    check("R7 idle ctrl", {16'd0, ctrl_out}, 32'd0);

    for (int i = 0; i < NV; i++)
      apply(VEC[i].ex, VEC[i].id, CW'(16'hA5C3 ^ i), VEC[i].exp,
            $sformatf("R%0d/R8 vec %0d", VEC[i].req, i));

    // R9: stalling pair, then bubble enters ID/EX with consumer held
    apply(enc(6'h23,3,9,0), enc(6'h00,9,4,8), 16'hFFFF, 1'b1, "R9 stall cycle");
    apply(32'd0, enc(6'h00,9,4,8), 16'h0000, 1'b0, "R9 release");
    // R7: all-ones control passes when no hazard
    apply(enc(6'h23,3,9,0), enc(6'h00,4,4,9), 16'hFFFF, 1'b0, "R7 pass");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule